// File: doc/BRIEF.md
# Dual-Mode Display Identification Stream Controller

This block fronts a 128-byte identification memory that a display exposes in two ways. At power-up it broadcasts the whole memory as one continuous serial stream on the data line. Each bit moves on when a slow, free-running stream clock (normally derived from vertical sync) rises. The stream starts at address 00h, sends each byte most significant bit first, and wraps from 7Fh back to 00h without a gap.

A falling edge on the I2C clock line shows that a host wants to address the device. The block then stops driving the data line and enters a waiting state. In that state an external I2C slave decodes the bus and, when it sees a valid control byte, reports it on a one-cycle strobe. That strobe puts the block into the addressed mode for good, and the slave keeps the bus from then on. If no control byte arrives and the stream clock delivers 128 rising edges with no further I2C clock falls, the block goes back to broadcasting from the start of the memory.

All pin inputs pass through a synchronizer and a minimum-width filter that run on the fast system clock. Memory reads use a plain synchronous port: read data appears one cycle after the address and enable.

Top module: `dualModeIdStream`

## Requirements
- R1: After reset the mode output is 0 (broadcast), `sdaOe` is 1, `memAddr` is 00h and `sdaOut` carries bit 7 of byte 00h.
- R2: In broadcast mode each accepted rising edge of `vclkIn` advances the stream by one bit. Bits go out most significant first, and `memAddr` shows the byte being sent.
- R3: After bit 0 of byte 7Fh, the stream continues with bit 7 of byte 00h.
- R4: A level on `vclkIn` or `sclIn` that lasts fewer than FILT_LEN system cycles after synchronization is ignored. It neither advances the stream nor changes the mode.
- R5: An accepted falling edge on `sclIn` in broadcast mode moves the mode to 1 (waiting) and drops `sdaOe` to 0.
- R6: `ctrlByteValid` in waiting mode moves the mode to 2 (addressed). The block stays in mode 2 until reset, whatever happens on `vclkIn` or `sclIn`. `ctrlByteValid` in broadcast mode has no effect.
- R7: In waiting mode, IDLE_PULSES (128) accepted `vclkIn` rising edges return the block to mode 0. Any accepted `sclIn` fall in between restarts that count from zero, so 127 edges before and 127 edges after such a fall do not leave mode 1.
- R8: On every return to broadcast mode, the stream restarts at bit 7 of byte 00h. While the block is not broadcasting, `memAddr` is held at 00h.
- R9: `modeOut` only ever takes the codes 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| vclkIn | input | 1 | Asynchronous stream clock pin |
| sclIn | input | 1 | Asynchronous I2C clock pin |
| ctrlByteValid | input | 1 | One-cycle strobe from the I2C slave: valid control byte received |
| memRdData | input | 8 | Memory read data, one cycle after the address |
| memAddr | output | 7 | Memory read address |
| memRdEn | output | 1 | Memory read enable (broadcast mode) |
| sdaOut | output | 1 | Serial stream bit |
| sdaOe | output | 1 | Data line output enable, high only while broadcasting |
| modeOut | output | 2 | 0 broadcast, 1 waiting, 2 addressed |

## Verification
A pin change becomes an accepted edge after two synchronizer cycles plus FILT_LEN filter cycles plus one edge-detect cycle, which is 7 cycles with the defaults. The mode register follows one cycle later. The new stream bit follows two cycles after the edge: one for the bit counter and one for the memory read together with the aligned bit select. The bench drives each pin level for 16 cycles and samples results 14 cycles after a change, on the falling system clock edge. That sample point is past every one of these latencies and before the next pin change. Expected bits come from a position counter over the bench's own memory image and pass through a scoreboard queue.

// File: rtl/ids_pkg.sv
package ids_pkg;
  typedef enum logic [1:0] {
    MODE_TX    = 2'd0,
    MODE_TRANS = 2'd1,
    MODE_BIDIR = 2'd2
  } idsMode_e;

  typedef struct packed {
    logic streamEn;
    logic advance;
  } idsStrobe_t;
endpackage

// File: rtl/idsInFilter.sv
module idsInFilter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 4,
  parameter logic RESET_VAL   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncVal;
  logic [CW-1:0]          stableCnt;
  logic                   filtQ;
  logic                   filtPrev;

  assign syncVal = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= {SYNC_STAGES{RESET_VAL}};
      stableCnt <= '0;
      filtQ     <= RESET_VAL;
      filtPrev  <= RESET_VAL;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], rawIn};
      filtPrev <= filtQ;
      if (syncVal == filtQ) begin
        stableCnt <= '0;
      end else if (stableCnt == CW'(FILT_LEN - 1)) begin
        filtQ     <= syncVal;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end

  assign rise = filtQ & ~filtPrev;
  assign fall = ~filtQ & filtPrev;
endmodule

// File: rtl/idsModeCtrl.sv
module idsModeCtrl
  import ids_pkg::*;
#(
  parameter int IDLE_PULSES = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vclkRise,
  input  logic       sclFall,
  input  logic       ctrlByteValid,
  output idsStrobe_t strobe,
  output logic [1:0] modeOut
);
  localparam int IW = $clog2(IDLE_PULSES + 1);

  idsMode_e        mode;
  logic [IW-1:0]   idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_TX;
      idleCnt <= '0;
    end else begin
      case (mode)
        MODE_TX: begin
          if (sclFall) begin
            mode    <= MODE_TRANS;
            idleCnt <= '0;
          end
        end
        MODE_TRANS: begin
          if (ctrlByteValid) begin
            mode <= MODE_BIDIR;
          end else if (sclFall) begin
            idleCnt <= '0;
          end else if (vclkRise) begin
            if (idleCnt == IW'(IDLE_PULSES - 1)) begin
              mode    <= MODE_TX;
              idleCnt <= '0;
            end else begin
              idleCnt <= idleCnt + 1'b1;
            end
          end
        end
        MODE_BIDIR: mode <= MODE_BIDIR;
        default:    mode <= MODE_TX;
      endcase
    end
  end

  always_comb begin
    strobe.streamEn = (mode == MODE_TX);
    strobe.advance  = (mode == MODE_TX) && vclkRise;
  end

  assign modeOut = mode;
endmodule

// File: rtl/idsStreamPath.sv
module idsStreamPath
  import ids_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  idsStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          memRdData,
  output logic [$clog2(DEPTH)-1:0]   memAddr,
  output logic                       memRdEn,
  output logic                       sdaOut,
  output logic                       sdaOe
);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(DATA_W);

  logic [AW-1:0] byteAddr;
  logic [BW-1:0] bitCnt;
  logic [BW-1:0] bitSelD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteAddr <= '0;
      bitCnt   <= '0;
      bitSelD  <= '0;
    end else begin
      bitSelD <= bitCnt;
      if (!strobe.streamEn) begin
        byteAddr <= '0;
        bitCnt   <= '0;
      end else if (strobe.advance) begin
        if (bitCnt == BW'(DATA_W - 1)) begin
          bitCnt   <= '0;
          byteAddr <= (byteAddr == AW'(DEPTH - 1)) ? '0 : byteAddr + 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign memAddr = byteAddr;
  assign memRdEn = strobe.streamEn;
  assign sdaOut  = memRdData[BW'(DATA_W - 1) - bitSelD];
  assign sdaOe   = strobe.streamEn;
endmodule

// File: rtl/dualModeIdStream.sv
module dualModeIdStream
  import ids_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int DATA_W      = 8,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_PULSES = 128,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vclkIn,
  input  logic              sclIn,
  input  logic              ctrlByteValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic [1:0]        modeOut
);
  logic       vclkRise;
  logic       vclkFall;
  logic       sclRise;
  logic       sclFall;
  idsStrobe_t strobe;

  idsInFilter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RESET_VAL(1'b0)) u_vclkFilt (
    .clk(clk), .rstN(rstN), .rawIn(vclkIn), .rise(vclkRise), .fall(vclkFall)
  );

  idsInFilter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RESET_VAL(1'b1)) u_sclFilt (
    .clk(clk), .rstN(rstN), .rawIn(sclIn), .rise(sclRise), .fall(sclFall)
  );

  idsModeCtrl #(.IDLE_PULSES(IDLE_PULSES)) u_ctrl (
    .clk(clk), .rstN(rstN), .vclkRise(vclkRise), .sclFall(sclFall),
    .ctrlByteValid(ctrlByteValid), .strobe(strobe), .modeOut(modeOut)
  );

  idsStreamPath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .memAddr(memAddr), .memRdEn(memRdEn), .sdaOut(sdaOut), .sdaOe(sdaOe)
  );

  logic unusedEdges;
  assign unusedEdges = vclkFall ^ sclRise;
endmodule

// File: rtl/dualModeIdStreamChk.sv
module dualModeIdStreamChk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeOut,
  input logic              sdaOe,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr
);
  a_r5_oe_only_broadcast: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (modeOut == 2'd0));

  a_r5_broadcast_exits_to_wait: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0) |=> (modeOut != 2'd2));

  a_r6_addressed_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd2) |=> (modeOut == 2'd2));

  a_r3_addr_steps_by_one: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (!memRdEn || memAddr == $past(memAddr) ||
                 memAddr == $past(memAddr) + ADDR_W'(1)));

  a_r8_addr_held_zero: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != 2'd0) |=> (memAddr == '0));

  a_r9_mode_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'd3);
endmodule

bind dualModeIdStream dualModeIdStreamChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeOut(modeOut), .sdaOe(sdaOe),
  .memRdEn(memRdEn), .memAddr(memAddr)
);

// File: tb/dualModeIdStream_tb.sv
module dualModeIdStream_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vclkIn = 1'b0;
  logic       sclIn = 1'b1;
  logic       ctrlByteValid = 1'b0;
  logic [7:0] memRdData;
  logic [6:0] memAddr;
  logic       memRdEn;
  logic       sdaOut;
  logic       sdaOe;
  logic [1:0] modeOut;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  logic [7:0] mem [128];
  logic  expQ [$];
  string tagQ [$];

  always #4 clk = ~clk;

  dualModeIdStream u_dut (
    .clk(clk), .rstN(rstN), .vclkIn(vclkIn), .sclIn(sclIn),
    .ctrlByteValid(ctrlByteValid), .memRdData(memRdData), .memAddr(memAddr),
    .memRdEn(memRdEn), .sdaOut(sdaOut), .sdaOe(sdaOe), .modeOut(modeOut)
  );

  always_ff @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic streamBit(input int p);
    int q = p % 1024;
    return mem[q / 8][7 - (q % 8)];
  endfunction

  task automatic pushBit(input string tag);
    expQ.push_back(streamBit(pos));
    tagQ.push_back(tag);
  endtask

  // monitor: pops expected stream bits and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        logic e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, int'(sdaOut), int'(e));
      end
    end
  end

  task automatic vclkPulse(input bit advance, input string tag);
    @(negedge clk); vclkIn = 1'b1;
    repeat (14) @(posedge clk);
    if (advance) begin pos++; pushBit(tag); end
    repeat (2) @(posedge clk);
    @(negedge clk); vclkIn = 1'b0;
    repeat (16) @(posedge clk);
  endtask

  task automatic sclFallPulse();
    @(negedge clk); sclIn = 1'b0;
    repeat (16) @(posedge clk);
    @(negedge clk); sclIn = 1'b1;
    repeat (16) @(posedge clk);
  endtask

  task automatic sampleAt(output logic [1:0] m, output logic oe);
    @(negedge clk); m = modeOut; oe = sdaOe;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] m;
    logic oe;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 29) ^ 8'h5A;
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    repeat (4) @(posedge clk);
    // R1 reset state
    sampleAt(m, oe);
    check("R1 mode", int'(m), 0);
    check("R1 oe", int'(oe), 1);
    check("R1 addr", int'(memAddr), 0);
    check("R1 first bit", int'(sdaOut), int'(streamBit(0)));

    // R2 and R3: full pass plus wrap
    for (int i = 0; i < 1030; i++) vclkPulse(1'b1, (pos >= 1016) ? "R3 wrap bit" : "R2 stream bit");
    @(negedge clk) check("R3 addr after wrap", int'(memAddr), (pos % 1024) / 8);

    // R4 vclk glitches shorter than the filter
    for (int g = 1; g <= 3; g++) begin
      @(negedge clk) vclkIn = 1'b1;
      repeat (g) @(negedge clk);
      vclkIn = 1'b0;
      repeat (16) @(posedge clk);
    end
    for (int i = 0; i < 16; i++) vclkPulse(1'b1, "R4 bit after vclk glitches");

    // R6 control strobe ignored while broadcasting
    @(negedge clk) ctrlByteValid = 1'b1;
    @(negedge clk) ctrlByteValid = 1'b0;
    repeat (14) @(posedge clk);
    sampleAt(m, oe);
    check("R6 strobe ignored in mode 0", int'(m), 0);

    // R4 scl glitch ignored
    @(negedge clk) sclIn = 1'b0;
    repeat (3) @(negedge clk);
    sclIn = 1'b1;
    repeat (16) @(posedge clk);
    sampleAt(m, oe);
    check("R4 scl glitch mode", int'(m), 0);
    check("R4 scl glitch oe", int'(oe), 1);

    // R5 scl fall enters waiting
    sclFallPulse();
    sampleAt(m, oe);
    check("R5 waiting mode", int'(m), 1);
    check("R5 oe dropped", int'(oe), 0);

    // R7 count restarted by scl fall
    for (int i = 0; i < 127; i++) vclkPulse(1'b0, "");
    sampleAt(m, oe);
    check("R7 still waiting after 127", int'(m), 1);
    sclFallPulse();
    for (int i = 0; i < 127; i++) vclkPulse(1'b0, "");
    sampleAt(m, oe);
    check("R7 count restarted by scl fall", int'(m), 1);
    vclkPulse(1'b0, "");
    sampleAt(m, oe);
    check("R7 return after 128", int'(m), 0);
    check("R7 oe restored", int'(oe), 1);

    // R8 restart at byte 00h bit 7
    check("R8 addr", int'(memAddr), 0);
    pos = 0;
    pushBit("R8 restart bit");
    for (int i = 0; i < 12; i++) vclkPulse(1'b1, "R8 stream after restart");

    // R6 addressed mode is sticky
    sclFallPulse();
    @(negedge clk) ctrlByteValid = 1'b1;
    @(negedge clk) ctrlByteValid = 1'b0;
    repeat (4) @(posedge clk);
    sampleAt(m, oe);
    check("R6 addressed", int'(m), 2);
    for (int i = 0; i < 200; i++) vclkPulse(1'b0, "");
    sclFallPulse();
    for (int i = 0; i < 130; i++) vclkPulse(1'b0, "");
    sampleAt(m, oe);
    check("R6 stays addressed", int'(m), 2);
    check("R6 oe low", int'(oe), 0);
    check("R8 addr held", int'(memAddr), 0);

    // R1 reset again
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    repeat (4) @(posedge clk);
    sampleAt(m, oe);
    check("R1 mode after second reset", int'(m), 0);
    check("R1 first bit after second reset", int'(sdaOut), int'(streamBit(0)));

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule